// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides, on every oscillator clock, whether a small 8-bit controller core is running, idling or powered down. Software issues a mode request through two strobes. The block then gates the CPU clock, the peripheral clock and the oscillator. It qualifies the raw reset pin into a core reset, and it wakes the core from idle when an enabled interrupt is pending. In the low-power modes it also sets the levels of the address-latch strobe, the program-fetch strobe and two port controls. In run mode those levels come from the core.

The reset pin first passes through a synchronizer. A free-running counter divides the oscillator clock into machine cycles of `MC_LEN` clocks, counted from power-on. The core reset is accepted only when the synchronized pin has stayed high through `MC_QUAL` complete consecutive machine cycles. Idle can be left by an interrupt or by reset. Power-down can be left only by a qualified reset. When reset ends idle, the CPU clock restarts at once. Writes to internal RAM are held off until the reset is accepted, while port writes are not held off. The `por_n` input clears the sequencer itself. It is separate from the core reset that the block produces.

Top module: `lpm_sequencer`

## Requirements
- R1: `core_rst_o` rises only on the last oscillator clock of a machine cycle. It rises only when the synchronized pin (two flops, so it lags `rst_pin_i` by two clocks) was high on every clock of the two machine cycles that end there. Each machine cycle is 12 clocks, with phase 0 being the first clock after `por_n` is released. `core_rst_o` falls one clock after the synchronized pin is low.
- R2: After `por_n` is released, `mode_o` is 0 (run), all three clock enables are 1, and both `core_rst_o` and `ram_wr_block_o` are 0.
- R3: In run mode with `core_rst_o` low, a `req_idle_i` pulse moves `mode_o` to 1 (idle) on the next clock. In idle, `cpu_clk_en_o` is 0 while `per_clk_en_o` and `osc_en_o` stay 1.
- R4: In idle with `core_rst_o` low, a high `irq_pend_i` returns `mode_o` to 0 on the next clock.
- R5: A `req_pd_i` pulse in run mode moves `mode_o` to 2 (power-down). In power-down, `cpu_clk_en_o` and `per_clk_en_o` are 0, and `irq_pend_i` has no effect on `mode_o`.
- R6: Power-down is left only when `core_rst_o` is high, which moves the mode to 0. In power-down, `osc_en_o` equals the synchronized pin, so the oscillator restarts for qualification.
- R7: If `req_idle_i` and `req_pd_i` are high on the same clock in run mode, the mode becomes 2.
- R8: In idle, when the synchronized pin is high and `irq_pend_i` is low, the mode becomes 3 (reset wake). In that mode `cpu_clk_en_o` and `ram_wr_block_o` are 1. The mode returns to 0 when `core_rst_o` is high or when the synchronized pin is low.
- R9: In modes 0 and 3, `ale_o` and `psen_o` follow `ale_core_i` and `psen_core_i`. In idle, both are 1. In power-down, both are 0.
- R10: `p0_float_o` is 1 in idle or power-down exactly when `ext_exec_i` is 1. `p2_addr_hold_o` is 1 only in idle with `ext_exec_i` at 1.
- R11: Mode requests are ignored outside run mode, and also while `core_rst_o` is high. A high `core_rst_o` forces mode 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on clear of the sequencer, active low, asynchronous |
| rst_pin_i | input | 1 | Raw reset pin, active high |
| req_idle_i | input | 1 | Idle request strobe from software |
| req_pd_i | input | 1 | Power-down request strobe from software |
| irq_pend_i | input | 1 | An enabled interrupt is pending |
| ext_exec_i | input | 1 | Code executes from external memory |
| ale_core_i | input | 1 | Address-latch strobe from the core in run mode |
| psen_core_i | input | 1 | Program-fetch strobe from the core in run mode |
| mode_o | output | 2 | 0 run, 1 idle, 2 power-down, 3 reset wake |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| per_clk_en_o | output | 1 | Peripheral clock gate enable |
| osc_en_o | output | 1 | Oscillator enable |
| core_rst_o | output | 1 | Qualified core reset |
| ram_wr_block_o | output | 1 | Blocks internal RAM writes |
| ale_o | output | 1 | Address-latch strobe pin level |
| psen_o | output | 1 | Program-fetch strobe pin level |
| p0_float_o | output | 1 | Port 0 drivers released to high impedance |
| p2_addr_hold_o | output | 1 | Port 2 keeps driving the address high byte |

## Verification
The bench raises the reset pin at different phases of the machine cycle. A qualifier that counts raw clocks, or that accepts one cycle too few, would raise the core reset on the wrong clock. It also pulses the pin for less than two machine cycles, where a design without qualification would reset the core. In idle it raises the pin and checks that the CPU restarts with RAM writes blocked. A design that missed this window would leave the CPU stalled, or would let RAM be corrupted before the reset lands. It also sends interrupts and requests in power-down, and both requests together. A wrong exit rule or a wrong priority would show up as a mode change there.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    LPM_RUN     = 2'd0,
    LPM_IDLE    = 2'd1,
    LPM_PD      = 2'd2,
    LPM_RSTWAKE = 2'd3
  } lpm_mode_e;
endpackage

// File: rtl/lpm_rst_qual.sv
module lpm_rst_qual #(
  parameter int MC_LEN      = 12,
  parameter int MC_QUAL     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_raw_i,
  output logic pin_s_o,
  output logic rst_q_o
);
  localparam int PH_W = (MC_LEN > 1) ? $clog2(MC_LEN) : 1;
  localparam int MH_W = $clog2(MC_QUAL + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(MC_LEN - 1);
  localparam logic [MH_W-1:0] MH_SAT  = MH_W'(MC_QUAL);
  localparam logic [MH_W-1:0] MH_NEED = MH_W'(MC_QUAL - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [PH_W-1:0]        phase_q;
  logic                   all_hi_q;
  logic [MH_W-1:0]        mc_hi_q;
  logic                   rst_q;
  logic                   pin_s;
  logic                   full;
  logic                   wrap;

  assign pin_s = sync_q[SYNC_STAGES-1];
  assign full  = all_hi_q & pin_s;
  assign wrap  = (phase_q == PH_LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= pin_raw_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase_q  <= '0;
      all_hi_q <= 1'b1;
      mc_hi_q  <= '0;
    end else if (wrap) begin
      phase_q  <= '0;
      all_hi_q <= 1'b1;
      if (!full)                mc_hi_q <= '0;
      else if (mc_hi_q != MH_SAT) mc_hi_q <= mc_hi_q + 1'b1;
    end else begin
      phase_q  <= phase_q + 1'b1;
      all_hi_q <= full;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                                  rst_q <= 1'b0;
    else if (!pin_s)                             rst_q <= 1'b0;
    else if (wrap && full && mc_hi_q >= MH_NEED) rst_q <= 1'b1;
  end

  assign pin_s_o = pin_s;
  assign rst_q_o = rst_q;

  // R1: reset may only appear on the last clock of a machine cycle
  a_r1_rise_on_boundary: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_q && !wrap) |=> !rst_q);
  // R1: reset releases as soon as the synchronized pin is low
  a_r1_release: assert property (@(posedge clk) disable iff (!por_n)
    !pin_s |=> !rst_q);
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      por_n,
  input  logic      rst_q_i,
  input  logic      pin_s_i,
  input  logic      req_idle_i,
  input  logic      req_pd_i,
  input  logic      irq_i,
  output lpm_mode_e state_o
);
  lpm_mode_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (rst_q_i) begin
      state_d = LPM_RUN;
    end else begin
      unique case (state_q)
        LPM_RUN: begin
          if (req_pd_i)        state_d = LPM_PD;
          else if (req_idle_i) state_d = LPM_IDLE;
        end
        LPM_IDLE: begin
          if (irq_i)        state_d = LPM_RUN;
          else if (pin_s_i) state_d = LPM_RSTWAKE;
        end
        LPM_PD:      state_d = LPM_PD;
        LPM_RSTWAKE: if (!pin_s_i) state_d = LPM_RUN;
        default:     state_d = LPM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state_q <= LPM_RUN;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R4: an interrupt ends idle
  a_r4_idle_irq_exit: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == LPM_IDLE && irq_i && !rst_q_i) |=> state_q == LPM_RUN);
  // R6: power-down is held until a qualified reset
  a_r6_pd_hold: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == LPM_PD && !rst_q_i) |=> state_q == LPM_PD);
  // R7: power-down wins over idle
  a_r7_pd_priority: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == LPM_RUN && req_pd_i && !rst_q_i) |=> state_q == LPM_PD);
  // R11: a qualified reset forces run
  a_r11_reset_to_run: assert property (@(posedge clk) disable iff (!por_n)
    rst_q_i |=> state_q == LPM_RUN);
endmodule

// File: rtl/lpm_pin_ctrl.sv
module lpm_pin_ctrl
  import lpm_pkg::*;
(
  input  lpm_mode_e state_i,
  input  logic      pin_s_i,
  input  logic      ext_exec_i,
  input  logic      ale_core_i,
  input  logic      psen_core_i,
  output logic      cpu_clk_en_o,
  output logic      per_clk_en_o,
  output logic      osc_en_o,
  output logic      ram_wr_block_o,
  output logic      ale_o,
  output logic      psen_o,
  output logic      p0_float_o,
  output logic      p2_addr_hold_o
);
  logic low_pwr;

  assign low_pwr = (state_i == LPM_IDLE) || (state_i == LPM_PD);

  always_comb begin
    cpu_clk_en_o   = 1'b1;
    per_clk_en_o   = 1'b1;
    osc_en_o       = 1'b1;
    ram_wr_block_o = 1'b0;
    ale_o          = ale_core_i;
    psen_o         = psen_core_i;
    unique case (state_i)
      LPM_IDLE: begin
        cpu_clk_en_o = 1'b0;
        ale_o        = 1'b1;
        psen_o       = 1'b1;
      end
      LPM_PD: begin
        cpu_clk_en_o = 1'b0;
        per_clk_en_o = 1'b0;
        osc_en_o     = pin_s_i;
        ale_o        = 1'b0;
        psen_o       = 1'b0;
      end
      LPM_RSTWAKE: ram_wr_block_o = 1'b1;
      default: ;
    endcase
  end

  assign p0_float_o     = low_pwr & ext_exec_i;
  assign p2_addr_hold_o = (state_i == LPM_IDLE) & ext_exec_i;
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int MC_LEN      = 12,
  parameter int MC_QUAL     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_osc,
  input  logic       por_n,
  input  logic       rst_pin_i,
  input  logic       req_idle_i,
  input  logic       req_pd_i,
  input  logic       irq_pend_i,
  input  logic       ext_exec_i,
  input  logic       ale_core_i,
  input  logic       psen_core_i,
  output logic [1:0] mode_o,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o,
  output logic       osc_en_o,
  output logic       core_rst_o,
  output logic       ram_wr_block_o,
  output logic       ale_o,
  output logic       psen_o,
  output logic       p0_float_o,
  output logic       p2_addr_hold_o
);
  logic      pin_s;
  logic      rst_q;
  lpm_mode_e state;

  lpm_rst_qual #(
    .MC_LEN(MC_LEN), .MC_QUAL(MC_QUAL), .SYNC_STAGES(SYNC_STAGES)
  ) u_qual (
    .clk(clk_osc), .por_n(por_n), .pin_raw_i(rst_pin_i),
    .pin_s_o(pin_s), .rst_q_o(rst_q)
  );

  lpm_mode_fsm u_fsm (
    .clk(clk_osc), .por_n(por_n), .rst_q_i(rst_q), .pin_s_i(pin_s),
    .req_idle_i(req_idle_i), .req_pd_i(req_pd_i), .irq_i(irq_pend_i),
    .state_o(state)
  );

  lpm_pin_ctrl u_pins (
    .state_i(state), .pin_s_i(pin_s), .ext_exec_i(ext_exec_i),
    .ale_core_i(ale_core_i), .psen_core_i(psen_core_i),
    .cpu_clk_en_o(cpu_clk_en_o), .per_clk_en_o(per_clk_en_o),
    .osc_en_o(osc_en_o), .ram_wr_block_o(ram_wr_block_o),
    .ale_o(ale_o), .psen_o(psen_o),
    .p0_float_o(p0_float_o), .p2_addr_hold_o(p2_addr_hold_o)
  );

  assign mode_o     = state;
  assign core_rst_o = rst_q;

  // R8: the RAM write block never outlives an accepted reset
  a_r8_block_ends_on_reset: assert property (@(posedge clk_osc) disable iff (!por_n)
    core_rst_o |=> !ram_wr_block_o);
  // R5: once in power-down without reset, the CPU clock stays off
  a_r5_pd_cpu_off: assert property (@(posedge clk_osc) disable iff (!por_n)
    (mode_o == 2'd2 && !core_rst_o) |=> !cpu_clk_en_o);
endmodule

// File: tb/test_lpm_sequencer.sv
module test_lpm_sequencer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic rst_pin = 1'b0, req_idle = 1'b0, req_pd = 1'b0, irq = 1'b0, ext = 1'b0;
  logic ale_core = 1'b0, psen_core = 1'b0;
  logic [1:0] mode;
  logic cpu_en, per_en, osc_en, core_rst, blk, ale, psen, p0f, p2a;

  int n_checks = 0, n_fail = 0;
  int cyc = 0;

  // reference model state
  int m_s1 = 0, m_s2 = 0, m_phase = 0, m_run = 0, m_rst = 0, m_mode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_sequencer i_lpm_sequencer (
    .clk_osc(clk), .por_n(por_n), .rst_pin_i(rst_pin),
    .req_idle_i(req_idle), .req_pd_i(req_pd), .irq_pend_i(irq),
    .ext_exec_i(ext), .ale_core_i(ale_core), .psen_core_i(psen_core),
    .mode_o(mode), .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en),
    .osc_en_o(osc_en), .core_rst_o(core_rst), .ram_wr_block_o(blk),
    .ale_o(ale), .psen_o(psen), .p0_float_o(p0f), .p2_addr_hold_o(p2a)
  );

  task automatic check(string req, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", req, cyc, got, exp);
    end
  endtask

  // Reference model: run-length of synchronized-high clocks, qualified at cycle ends
  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_s1 = 0; m_s2 = 0; m_phase = 0; m_run = 0; m_rst = 0; m_mode = 0;
    end else begin
      int run_incl, nmode, nrst;
      run_incl = (m_s2 != 0) ? ((m_run < 1000) ? m_run + 1 : m_run) : 0;
      if (m_rst != 0) nmode = 0;
      else case (m_mode)
        0: nmode = req_pd ? 2 : (req_idle ? 1 : 0);
        1: nmode = irq ? 0 : ((m_s2 != 0) ? 3 : 1);
        2: nmode = 2;
        default: nmode = (m_s2 != 0) ? 3 : 0;
      endcase
      if (m_s2 == 0) nrst = 0;
      else if (m_phase == 11 && run_incl >= 24) nrst = 1;
      else nrst = m_rst;
      m_mode = nmode; m_rst = nrst; m_run = run_incl;
      m_phase = (m_phase + 1) % 12;
      m_s2 = m_s1; m_s1 = int'(rst_pin);
    end
  end

  // core strobe stimulus and per-clock comparison
  always @(negedge clk) begin
    cyc++;
    ale_core  <= cyc[0];
    psen_core <= cyc[1] ^ cyc[3];
    #1;
    if (por_n) begin
      check("R3 mode", int'(mode), m_mode);
      check("R3 cpu_clk_en", int'(cpu_en), (m_mode == 0 || m_mode == 3) ? 1 : 0);
      check("R5 per_clk_en", int'(per_en), (m_mode != 2) ? 1 : 0);
      check("R6 osc_en", int'(osc_en), (m_mode != 2 || m_s2 != 0) ? 1 : 0);
      check("R1 core_rst", int'(core_rst), m_rst);
      check("R8 ram_wr_block", int'(blk), (m_mode == 3) ? 1 : 0);
      check("R9 ale", int'(ale), (m_mode == 1) ? 1 : (m_mode == 2) ? 0 : int'(ale_core));
      check("R9 psen", int'(psen), (m_mode == 1) ? 1 : (m_mode == 2) ? 0 : int'(psen_core));
      check("R10 p0_float", int'(p0f), ((m_mode == 1 || m_mode == 2) && ext) ? 1 : 0);
      check("R10 p2_addr_hold", int'(p2a), (m_mode == 1 && ext) ? 1 : 0);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #3; end
  endtask

  task automatic wait_rst(string req, int lo, int hi);
    int n = 0;
    while (!core_rst && n < 80) begin tick(); n++; end
    check(req, (n >= lo && n <= hi) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    por_n = 1'b1;
    tick();
    check("R2 mode after power-on", int'(mode), 0);
    check("R2 clocks after power-on", int'({cpu_en, per_en, osc_en}), 7);
    check("R2 reset/block after power-on", int'({core_rst, blk}), 0);
    tick(5);

    ext = 1'b1;
    req_idle = 1'b1; tick(); req_idle = 1'b0;
    check("R3 idle entered", int'(mode), 1);
    tick(4);
    req_pd = 1'b1; tick(); req_pd = 1'b0;
    check("R11 request ignored in idle", int'(mode), 1);
    irq = 1'b1; tick(); irq = 1'b0;
    check("R4 irq exits idle", int'(mode), 0);
    tick(3);

    req_idle = 1'b1; req_pd = 1'b1; tick(); req_idle = 1'b0; req_pd = 1'b0;
    check("R7 power-down priority", int'(mode), 2);
    check("R5 oscillator stopped", int'(osc_en), 0);
    irq = 1'b1; tick(3); irq = 1'b0;
    check("R5 irq ignored in power-down", int'(mode), 2);
    ext = 1'b0;
    tick(7);
    rst_pin = 1'b1; tick(3);
    check("R6 oscillator restarts on pin", int'(osc_en), 1);
    wait_rst("R1 qualification delay from power-down", 20, 36);
    tick();
    check("R6 reset exits power-down", int'(mode), 0);
    req_idle = 1'b1; tick(); req_idle = 1'b0;
    check("R11 request ignored during reset", int'(mode), 0);
    rst_pin = 1'b0; tick(3);
    check("R1 reset released", int'(core_rst), 0);

    ext = 1'b1;
    req_idle = 1'b1; tick(); req_idle = 1'b0;
    tick(2);
    rst_pin = 1'b1; tick(3);
    check("R8 reset wake mode", int'(mode), 3);
    check("R8 ram writes blocked", int'(blk), 1);
    tick(8);
    rst_pin = 1'b0; tick(3);
    check("R8 short pulse returns to run", int'(mode), 0);
    check("R1 short pulse no reset", int'(core_rst), 0);

    req_idle = 1'b1; tick(); req_idle = 1'b0;
    tick(5);
    rst_pin = 1'b1;
    wait_rst("R1 qualification delay from idle", 25, 37);
    tick();
    check("R8 reset ends wake", int'({mode, blk}), 0);
    rst_pin = 1'b0; tick(4);

    for (int k = 0; k < 3; k++) begin
      rst_pin = 1'b1; tick(20 + k); rst_pin = 1'b0; tick(3);
      check("R1 pulse under two cycles", int'(core_rst), 0);
      tick(k * 5);
    end
    ext = 1'b0;
    req_idle = 1'b1; tick(); req_idle = 1'b0;
    tick(6);
    irq = 1'b1; tick(); irq = 1'b0;
    check("R4 irq exits idle internal", int'(mode), 0);
    tick(20);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule